// File: doc/BRIEF.md
# Receive Idle Time-out Counter

This block is a down-counting counter/timer shared by two serial receive channels. In its ordinary mode, software starts and stops it through commands, and it counts a loaded preload value down to zero. Each channel can also place it in a receive time-out mode. In that mode the receive data stream controls the counter. Every character a receiver places into its FIFO retriggers the count. If the receivers stay quiet for longer than the programmed period, the counter raises a ready flag and, when unmasked, an interrupt.

The typical use is to catch a message tail left in a receive FIFO that has not filled up far enough to interrupt on its own. Software programs a period slightly longer than one character time and enables the mode on the channel of interest. The interrupt then fires shortly after the data stream stops. The counter advances only on cycles where the C/T clock enable is high.

Top module: `rx_idle_timer`

## Requirements
- R1: A byte write of 0x0A to a channel's command address (address 2 for channel 0, address 3 for channel 1) enables time-out mode for that channel. A write of 0x0C disables it. The mode is active while any channel has it enabled.
- R2: An enable write (0x0A) clears the ready flag and leaves the counter stopped at its current value until the next character event.
- R3: After a character event in time-out mode, the first C/T tick loads the preload value. The second tick restarts the counter without decrementing. Each later tick decrements the count by one.
- R4: When a tick takes the count from 1 to 0, the ready flag (status address 5, bit 3) is set. The count then stays at 0 and does not reload until the next character event.
- R5: `irq_o` is high exactly when the ready flag is set and bit 3 of the mask register (address 4) is set.
- R6: A character event in time-out mode clears the ready flag, and with it the interrupt, on the next cycle.
- R7: In time-out mode the start (0x01) and stop (0x02) commands have no effect on the count or its running state.
- R8: The restart trigger is the OR of both channels' FIFO-load strobes. A strobe on either enabled channel alone retriggers the count.
- R9: Disabling the last enabled channel returns the counter to command control in the stopped state. Character strobes are then ignored.
- R10: Reads of address 0 and address 1 return the low and high bytes of the current count. Writing the preload bytes (same addresses) leaves the current count unchanged until the next reload.
- R11: A preload of zero loads 65536 counts. The first decrement after such a load reads back 0xFFFF.
- R12: In ordinary mode, a start command loads the preload and runs the counter, and a stop command halts it. Both clear the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on the address) |
| ct_en | input | 1 | C/T clock enable, one count step per high cycle |
| chr_load | input | 2 | Per-channel character-to-FIFO load strobes |
| irq_o | output | 1 | Counter-ready interrupt |

## Verification
The time-out path is driven with a strobe on channel 0 only, a strobe on channel 1 only, and both channels enabled together. These three cases separate the per-channel enables from the ORed trigger, and show that disabling one channel leaves the mode running. The tick-by-tick count after a strobe is read back from the first tick onward. This separates the reload tick and the silent restart tick from an early decrement, and shows the exact tick on which the flag rises. Ordinary-mode start and stop commands, and a zero preload, are applied both inside and outside the mode. This separates commands that are ignored from those that act, and confirms that the zero preload wraps through 0xFFFF.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ARM    = 2'd1,
    PH_RELOAD = 2'd2,
    PH_RUN    = 2'd3
  } phase_t;

  localparam int unsigned ADDR_CNT_LO = 0;
  localparam int unsigned ADDR_CNT_HI = 1;
  localparam int unsigned ADDR_CMD0   = 2;
  localparam int unsigned ADDR_MASK   = 4;
  localparam int unsigned ADDR_STAT   = 5;

  localparam logic [7:0] CMD_START  = 8'h01;
  localparam logic [7:0] CMD_STOP   = 8'h02;
  localparam logic [7:0] CMD_TO_ON  = 8'h0A;
  localparam logic [7:0] CMD_TO_OFF = 8'h0C;

  localparam int unsigned READY_BIT = 3;
endpackage

// File: rtl/rxto_cmd_dec.sv
module rxto_cmd_dec
  import rxto_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [CW-1:0]  pre_q,
  output logic [DW-1:0]  mask_q,
  output logic           mode_q,
  output logic           en_cmd,
  output logic           mode_off,
  output logic           start_p,
  output logic           stop_p
);
  localparam int unsigned NB = CW / DW;

  logic [NCH-1:0] hit, en_q, en_d;
  logic [CW-1:0]  pre_d;
  logic [DW-1:0]  mask_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] CADDR = AW'(ADDR_CMD0 + c);
    assign hit[c] = wr && (addr == CADDR);
    always_comb begin
      en_d[c] = en_q[c];
      if (hit[c] && wdata == CMD_TO_ON)  en_d[c] = 1'b1;
      if (hit[c] && wdata == CMD_TO_OFF) en_d[c] = 1'b0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_pre
    localparam logic [AW-1:0] BADDR = AW'(ADDR_CNT_LO + b);
    assign pre_d[b*DW +: DW] = (wr && addr == BADDR) ? wdata : pre_q[b*DW +: DW];
  end

  assign mask_d   = (wr && addr == AW'(ADDR_MASK)) ? wdata : mask_q;
  assign en_cmd   = (|hit) && (wdata == CMD_TO_ON);
  assign start_p  = (|hit) && (wdata == CMD_START);
  assign stop_p   = (|hit) && (wdata == CMD_STOP);
  assign mode_q   = |en_q;
  assign mode_off = (|en_q) && !(|en_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pre_q  <= '0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      pre_q  <= pre_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter
  import rxto_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          chr_evt,
  input  logic          mode_q,
  input  logic          en_cmd,
  input  logic          mode_off,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [CW-1:0] pre,
  output logic [CW:0]   cnt_q,
  output logic          ready_q
);
  phase_t      ph_q, ph_d;
  logic [CW:0] cnt_d, load_val;
  logic        ready_d;

  assign load_val = (pre == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, pre};

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    ready_d = ready_q;
    if (mode_off) begin
      ph_d = PH_IDLE;
    end else if (en_cmd) begin
      ph_d    = PH_IDLE;
      ready_d = 1'b0;
    end else if (mode_q && chr_evt) begin
      ph_d    = PH_ARM;
      ready_d = 1'b0;
    end else if (!mode_q && start_p) begin
      ph_d    = PH_RUN;
      cnt_d   = load_val;
      ready_d = 1'b0;
    end else if (!mode_q && stop_p) begin
      ph_d    = PH_IDLE;
      ready_d = 1'b0;
    end else if (tick) begin
      unique case (ph_q)
        PH_ARM: begin
          cnt_d = load_val;
          ph_d  = PH_RELOAD;
        end
        PH_RELOAD: ph_d = PH_RUN;
        PH_RUN: begin
          if (cnt_q <= (CW+1)'(1)) begin
            cnt_d   = '0;
            ready_d = 1'b1;
            ph_d    = PH_IDLE;
          end else begin
            cnt_d = cnt_q - (CW+1)'(1);
          end
        end
        default: ph_d = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rxto_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           ct_en,
  input  logic [NCH-1:0] chr_load,
  output logic           irq_o
);
  logic [1:0]    rst_sync;
  logic          rst_s_n;
  logic [CW-1:0] pre_q;
  logic [DW-1:0] mask_q;
  logic          mode_q, en_cmd, mode_off, start_p, stop_p, chr_evt;
  logic [CW:0]   cnt_q;
  logic          ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  rxto_cmd_dec #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_s_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pre_q(pre_q), .mask_q(mask_q), .mode_q(mode_q), .en_cmd(en_cmd),
    .mode_off(mode_off), .start_p(start_p), .stop_p(stop_p)
  );

  assign chr_evt = |chr_load;

  rxto_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick(ct_en), .chr_evt(chr_evt), .mode_q(mode_q),
    .en_cmd(en_cmd), .mode_off(mode_off), .start_p(start_p), .stop_p(stop_p),
    .pre(pre_q), .cnt_q(cnt_q), .ready_q(ready_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADDR_CNT_LO))      reg_rdata = cnt_q[DW-1:0];
    else if (reg_addr == AW'(ADDR_CNT_HI)) reg_rdata = cnt_q[2*DW-1:DW];
    else if (reg_addr == AW'(ADDR_MASK))   reg_rdata = mask_q;
    else if (reg_addr == AW'(ADDR_STAT))   reg_rdata[READY_BIT] = ready_q;
  end

  assign irq_o = ready_q && mask_q[READY_BIT];
endmodule

// File: rtl/rxto_chk.sv
module rxto_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ct_en,
  input logic          start_p,
  input logic          en_cmd,
  input logic          chr_evt,
  input logic          mode_q,
  input logic [CW:0]   cnt_q,
  input logic          ready_q,
  input logic [DW-1:0] mask_q,
  input logic          irq_o
);
  // R3: without a tick or a start command the count never moves
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ct_en && !start_p) |=> $stable(cnt_q));

  // R4: the flag only rises together with a zero count
  assert_ready_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> (cnt_q == '0));

  // R5: interrupt needs both the flag and the mask bit
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ready_q && mask_q[3]));

  // R6: a character in time-out mode clears the flag
  assert_char_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_evt && mode_q) |=> !ready_q);

  // R2: an enable command clears the flag
  assert_enable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd |=> !ready_q);
endmodule

bind rx_idle_timer rxto_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .ct_en(ct_en), .start_p(start_p), .en_cmd(en_cmd),
  .chr_evt(chr_evt), .mode_q(mode_q), .cnt_q(cnt_q), .ready_q(ready_q),
  .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/rx_idle_timer_tb.sv
module rx_idle_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ct_en = 1'b0;
  logic [1:0] chr_load = '0;
  logic       irq_o;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rx_idle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ct_en(ct_en),
    .chr_load(chr_load), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ct_en = 1'b1;
      @(negedge clk); ct_en = 1'b0;
    end
  endtask

  task automatic chr(input logic [1:0] m);
    @(negedge clk); chr_load = m;
    @(negedge clk); chr_load = '0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic cnt_is(input string req, input int exp);
    int lo, hi;
    rd(3'd0, lo); rd(3'd1, hi);
    chk(req, (hi << 8) | lo, exp);
  endtask

  task automatic rdy_is(input string req, input int exp);
    int s;
    rd(3'd5, s);
    chk(req, (s >> 3) & 1, exp);
  endtask

  task automatic t_reset();
    cnt_is("R10 reset count", 0);
    rdy_is("R4 reset ready", 0);
    chk("R5 reset irq", irq_o, 0);
  endtask

  task automatic t_timeout_seq();
    wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd4, 8'h08);
    wr(3'd2, 8'h0A);
    tick(2);
    cnt_is("R2 stopped until char", 0);
    chr(2'b01);
    tick(1); cnt_is("R3 reload tick", 3);
    tick(1); cnt_is("R3 restart tick", 3);
    tick(1); cnt_is("R3 first decrement", 2);
    tick(1); cnt_is("R3 second decrement", 1);
    rdy_is("R4 not ready early", 0);
    tick(1); cnt_is("R4 reaches zero", 0);
    rdy_is("R4 ready set", 1);
    chk("R5 irq with mask", irq_o, 1);
    tick(3); cnt_is("R4 holds at zero", 0);
    chr(2'b01);
    rdy_is("R6 char clears ready", 0);
    chk("R6 irq cleared", irq_o, 0);
  endtask

  task automatic t_ignore_cmds();
    tick(3); cnt_is("R7 running", 2);
    wr(3'd2, 8'h02);
    tick(1); cnt_is("R7 stop ignored", 1);
    wr(3'd0, 8'd9);
    cnt_is("R10 preload write keeps count", 1);
    wr(3'd2, 8'h01);
    cnt_is("R7 start ignored", 1);
    tick(1); rdy_is("R4 timeout again", 1);
    chr(2'b01); tick(2); cnt_is("R10 new preload on reload", 9);
  endtask

  task automatic t_or_channels();
    tick(9); rdy_is("R4 ready before enable", 1);
    wr(3'd3, 8'h0A);
    rdy_is("R2 enable clears ready", 0);
    cnt_is("R2 enable stops count", 0);
    wr(3'd0, 8'd4);
    chr(2'b10); tick(2); cnt_is("R8 ch1 alone retriggers", 4);
    tick(3); chr(2'b01); tick(2); cnt_is("R8 ch0 retriggers", 4);
    tick(3); chr(2'b10); tick(3); cnt_is("R8 mixed", 3);
    rdy_is("R8 no timeout while active", 0);
    wr(3'd4, 8'h00);
    tick(3); rdy_is("R5 ready masked", 1);
    chk("R5 irq masked", irq_o, 0);
  endtask

  task automatic t_disable();
    wr(3'd2, 8'h0C);
    chr(2'b10); tick(2); cnt_is("R1 ch1 keeps mode", 4);
    tick(1);
    wr(3'd3, 8'h0C);
    tick(2); cnt_is("R9 stopped after last disable", 3);
    chr(2'b11); tick(2); cnt_is("R9 char ignored", 3);
    wr(3'd2, 8'h0A);
    chr(2'b01); tick(2); cnt_is("R1 re-enable ch0", 4);
    wr(3'd2, 8'h0C);
  endtask

  task automatic t_normal();
    wr(3'd0, 8'd0); wr(3'd1, 8'd0);
    wr(3'd2, 8'h01);
    cnt_is("R11 zero preload reads low 16", 0);
    tick(1); cnt_is("R11 wrap to FFFF", 16'hFFFF);
    tick(1); cnt_is("R12 run decrements", 16'hFFFE);
    wr(3'd3, 8'h02);
    tick(2); cnt_is("R12 stop halts", 16'hFFFE);
    wr(3'd0, 8'd2);
    wr(3'd2, 8'h01);
    cnt_is("R12 start loads", 2);
    tick(2); rdy_is("R12 ready at zero", 1);
    wr(3'd2, 8'h02);
    rdy_is("R12 stop clears ready", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_timeout_seq();
    t_ignore_cmds();
    t_or_channels();
    t_disable();
    t_normal();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule